// File: doc/BRIEF.md
# Link packet framer

This block turns packets handed over from the link layer into the byte stream for one lane of a serial link. It emits at most one byte per clock. Two packet kinds share the output. A transaction packet arrives as a byte stream: a 3- or 4-doubleword header, then an optional payload of 0 to 1024 doublewords, and, if present, its end-to-end check word. The framer wraps this stream in a start symbol, a 16-bit sequence field, a 32-bit link check value and an end symbol. A link-control packet arrives as exactly four body bytes. The framer wraps it in its own start symbol, a 16-bit check value and the same end symbol.

The upstream source presents bytes with a valid/ready handshake. It holds `inCtrl` steady for the whole packet to choose the kind, and marks the final transaction byte with `inLast`. The framer takes no body bytes while it emits markers, sequence bytes or check bytes. It takes the next packet only after the end symbol of the current one has been sent. When the source stalls, the output shows a cycle with `outValid` low. The byte content is not affected.

Top module: `link_framer`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `outValid` and `inReady` are low. The first transaction packet after reset carries sequence number 0.
- R2: A transaction packet (`inCtrl`=0) is emitted in this order. First a start symbol 0xFB, then the high and low sequence bytes, then every accepted body byte in arrival order, then four link-check bytes, then an end symbol 0xFD. The body ends with the byte accepted while `inLast` is 1.
- R3: The sequence number is 12 bits wide. It is sent as a 16-bit field with its top 4 bits zero: the high byte first, then the low byte. It advances by one after each transaction packet and wraps from 4095 to 0.
- R4: The link check is a CRC with polynomial 0x04C11DB7 and all-ones seed. Each byte is fed most-significant bit first. It covers the two sequence bytes and every body byte. It is sent inverted, most-significant byte first.
- R5: A link-control packet (`inCtrl`=1) is emitted in this order: start symbol 0x5C, exactly four body bytes, two check bytes, end symbol 0xFD. `inLast` has no effect on its length.
- R6: The control check is a CRC with polynomial 0x100B and all-ones seed. Each byte is fed most-significant bit first. It covers only the four body bytes and is sent uninverted, most-significant byte first.
- R7: `outK` is 1 on start and end symbols and 0 on every sequence, body and check byte.
- R8: `inReady` is low while a start symbol, a sequence byte, a check byte or an end symbol is being produced. A packet begins only after the previous end symbol has been sent.
- R9: Link-control packets do not advance the sequence number.
- R10: When the source stalls mid-body, `outValid` drops for those cycles. The emitted byte sequence is identical to that of an unstalled packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| inValid | input | 1 | Source has a byte (or a pending packet) |
| inReady | output | 1 | Framer takes the presented byte this cycle |
| inData | input | 8 | Body byte |
| inLast | input | 1 | Final body byte of a transaction packet |
| inCtrl | input | 1 | Packet kind: 0 transaction, 1 link-control |
| outValid | output | 1 | Output byte present |
| outData | output | 8 | Output byte |
| outK | output | 1 | Output byte is a control symbol |

## Verification
Transaction packets are tried with a bare 12-byte header and with a 16-byte header plus a 32-byte payload. The payload case is fed with periodic source stalls, which separates correct check accumulation from accidental feeding on idle cycles. Link-control packets are sent with `inLast` raised on their second byte. This exposes a framer that ends the body early or uses the wrong check width or polynomial. A transaction packet sent after the control packets shows whether control traffic wrongly advances the sequence. A long run of one-byte transaction packets drives the sequence through its wrap, where a field width or masking error in the high byte would show.

// File: rtl/lf_pkg.sv
package lf_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    SRC_START_TLP,
    SRC_START_CTL,
    SRC_SEQ_HI,
    SRC_SEQ_LO,
    SRC_BODY,
    SRC_CRC32,
    SRC_CRC16,
    SRC_END
  } byteSrcT;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic    emit;
    byteSrcT src;
    logic [1:0] crcIdx;
    logic    crcInit;
    logic    feed32;
    logic    feed16;
    logic    seqInc;
  } strobeT;
endpackage

// File: rtl/lf_crc.sv
module lf_crc #(
  parameter int WIDTH = 32,
  parameter logic [WIDTH-1:0] POLY = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             init,
  input  logic             feed,
  input  logic [7:0]       dataIn,
  output logic [WIDTH-1:0] crcQ
);
  logic [WIDTH-1:0] crcNext;

  // Non-reflected update, byte fed most-significant bit first
  always_comb begin
    crcNext = crcQ;
    for (int b = 7; b >= 0; b--) begin
      if (crcNext[WIDTH-1] ^ dataIn[b]) crcNext = (crcNext << 1) ^ POLY;
      else                              crcNext = crcNext << 1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     crcQ <= '1;
    else if (init) crcQ <= '1;
    else if (feed) crcQ <= crcNext;
  end
endmodule

// File: rtl/lf_ctrl.sv
module lf_ctrl
  import lf_pkg::*;
#(
  parameter int CTL_BODY_BYTES = 4
) (
  input  logic   clk,
  input  logic   rstN,
  input  logic   inValid,
  input  logic   inLast,
  input  logic   inCtrl,
  output logic   inReady,
  output strobeT strobe
);
  localparam int CNT_W = (CTL_BODY_BYTES > 4) ? $clog2(CTL_BODY_BYTES) : 2;
  localparam int LINK_CRC_BYTES = 4;
  localparam int CTL_CRC_BYTES  = 2;

  typedef enum logic [2:0] {ST_IDLE, ST_SEQH, ST_SEQL, ST_BODY, ST_CRC, ST_END} stateT;

  stateT stateQ, stateD;
  logic isCtlQ, isCtlD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic bodyLast, crcLast;

  assign bodyLast = isCtlQ ? (cntQ == CNT_W'(CTL_BODY_BYTES - 1)) : inLast;
  assign crcLast  = isCtlQ ? (cntQ == CNT_W'(CTL_CRC_BYTES - 1))
                           : (cntQ == CNT_W'(LINK_CRC_BYTES - 1));

  always_comb begin
    stateD  = stateQ;
    isCtlD  = isCtlQ;
    cntD    = cntQ;
    inReady = 1'b0;
    strobe  = '0;
    case (stateQ)
      ST_IDLE: begin
        if (inValid) begin
          strobe.emit    = 1'b1;
          strobe.src     = inCtrl ? SRC_START_CTL : SRC_START_TLP;
          strobe.crcInit = 1'b1;
          isCtlD         = inCtrl;
          cntD           = '0;
          stateD         = inCtrl ? ST_BODY : ST_SEQH;
        end
      end
      ST_SEQH: begin
        strobe.emit   = 1'b1;
        strobe.src    = SRC_SEQ_HI;
        strobe.feed32 = 1'b1;
        stateD        = ST_SEQL;
      end
      ST_SEQL: begin
        strobe.emit   = 1'b1;
        strobe.src    = SRC_SEQ_LO;
        strobe.feed32 = 1'b1;
        stateD        = ST_BODY;
      end
      ST_BODY: begin
        inReady = 1'b1;
        if (inValid) begin
          strobe.emit   = 1'b1;
          strobe.src    = SRC_BODY;
          strobe.feed32 = !isCtlQ;
          strobe.feed16 = isCtlQ;
          if (bodyLast) begin
            cntD   = '0;
            stateD = ST_CRC;
          end else begin
            cntD = cntQ + 1'b1;
          end
        end
      end
      ST_CRC: begin
        strobe.emit   = 1'b1;
        strobe.src    = isCtlQ ? SRC_CRC16 : SRC_CRC32;
        strobe.crcIdx = cntQ[1:0];
        if (crcLast) stateD = ST_END;
        else         cntD   = cntQ + 1'b1;
      end
      ST_END: begin
        strobe.emit   = 1'b1;
        strobe.src    = SRC_END;
        strobe.seqInc = !isCtlQ;
        stateD        = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      isCtlQ <= 1'b0;
      cntQ   <= '0;
    end else begin
      stateQ <= stateD;
      isCtlQ <= isCtlD;
      cntQ   <= cntD;
    end
  end
endmodule

// File: rtl/lf_datapath.sv
module lf_datapath
  import lf_pkg::*;
#(
  parameter int          SEQ_W         = 12,
  parameter logic [31:0] CRC32_POLY    = 32'h04C11DB7,
  parameter logic [15:0] CRC16_POLY    = 16'h100B,
  parameter logic [7:0]  START_TLP_SYM = 8'hFB,
  parameter logic [7:0]  START_CTL_SYM = 8'h5C,
  parameter logic [7:0]  END_SYM       = 8'hFD
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [BYTE_W-1:0] inData,
  output logic              outValid,
  output logic [BYTE_W-1:0] outData,
  output logic              outK
);
  localparam int SEQ_FIELD_W = 2 * BYTE_W;

  logic [SEQ_W-1:0]       seqQ;
  logic [SEQ_FIELD_W-1:0] seqField;
  logic [31:0]            crc32Q, crc32Inv;
  logic [15:0]            crc16Q;
  logic [BYTE_W-1:0]      byteNext;
  logic                   kNext;

  assign seqField = SEQ_FIELD_W'(seqQ);
  assign crc32Inv = ~crc32Q;

  always_comb begin
    kNext    = 1'b0;
    byteNext = inData;
    case (strobe.src)
      SRC_START_TLP: begin byteNext = START_TLP_SYM; kNext = 1'b1; end
      SRC_START_CTL: begin byteNext = START_CTL_SYM; kNext = 1'b1; end
      SRC_END:       begin byteNext = END_SYM;       kNext = 1'b1; end
      SRC_SEQ_HI:    byteNext = seqField[SEQ_FIELD_W-1 -: BYTE_W];
      SRC_SEQ_LO:    byteNext = seqField[BYTE_W-1:0];
      SRC_CRC32: begin
        case (strobe.crcIdx)
          2'd0:    byteNext = crc32Inv[31:24];
          2'd1:    byteNext = crc32Inv[23:16];
          2'd2:    byteNext = crc32Inv[15:8];
          default: byteNext = crc32Inv[7:0];
        endcase
      end
      SRC_CRC16:     byteNext = strobe.crcIdx[0] ? crc16Q[7:0] : crc16Q[15:8];
      default:       byteNext = inData;
    endcase
  end

  lf_crc #(.WIDTH(32), .POLY(CRC32_POLY)) uCrcLink (
    .clk(clk), .rstN(rstN), .init(strobe.crcInit), .feed(strobe.feed32),
    .dataIn(byteNext), .crcQ(crc32Q)
  );

  lf_crc #(.WIDTH(16), .POLY(CRC16_POLY)) uCrcCtl (
    .clk(clk), .rstN(rstN), .init(strobe.crcInit), .feed(strobe.feed16),
    .dataIn(byteNext), .crcQ(crc16Q)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ     <= '0;
      outValid <= 1'b0;
      outData  <= '0;
      outK     <= 1'b0;
    end else begin
      outValid <= strobe.emit;
      if (strobe.emit) begin
        outData <= byteNext;
        outK    <= kNext;
      end
      if (strobe.seqInc) seqQ <= seqQ + 1'b1;
    end
  end
endmodule

// File: rtl/link_framer.sv
module link_framer #(
  parameter int          SEQ_W          = 12,
  parameter int          CTL_BODY_BYTES = 4,
  parameter logic [31:0] CRC32_POLY     = 32'h04C11DB7,
  parameter logic [15:0] CRC16_POLY     = 16'h100B,
  parameter logic [7:0]  START_TLP_SYM  = 8'hFB,
  parameter logic [7:0]  START_CTL_SYM  = 8'h5C,
  parameter logic [7:0]  END_SYM        = 8'hFD
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output logic       inReady,
  input  logic [7:0] inData,
  input  logic       inLast,
  input  logic       inCtrl,
  output logic       outValid,
  output logic [7:0] outData,
  output logic       outK
);
  lf_pkg::strobeT strobe;

  lf_ctrl #(.CTL_BODY_BYTES(CTL_BODY_BYTES)) uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inLast(inLast),
    .inCtrl(inCtrl), .inReady(inReady), .strobe(strobe)
  );

  lf_datapath #(
    .SEQ_W(SEQ_W), .CRC32_POLY(CRC32_POLY), .CRC16_POLY(CRC16_POLY),
    .START_TLP_SYM(START_TLP_SYM), .START_CTL_SYM(START_CTL_SYM), .END_SYM(END_SYM)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inData(inData),
    .outValid(outValid), .outData(outData), .outK(outK)
  );
endmodule

// File: rtl/link_framer_chk.sv
module link_framer_chk #(
  parameter int         SEQ_W          = 12,
  parameter int         CTL_BODY_BYTES = 4,
  parameter logic [7:0] START_TLP_SYM  = 8'hFB,
  parameter logic [7:0] START_CTL_SYM  = 8'h5C,
  parameter logic [7:0] END_SYM        = 8'hFD
) (
  input logic       clk,
  input logic       rstN,
  input logic       inReady,
  input logic       outValid,
  input logic [7:0] outData,
  input logic       outK
);
  logic [15:0] cntQ;
  logic        ctlQ, inPktQ;
  logic        isStartT, isStartC, isEnd;

  assign isStartT = outValid && outK && (outData == START_TLP_SYM);
  assign isStartC = outValid && outK && (outData == START_CTL_SYM);
  assign isEnd    = outValid && outK && (outData == END_SYM);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ   <= '0;
      ctlQ   <= 1'b0;
      inPktQ <= 1'b0;
    end else if (outValid) begin
      if (isStartT || isStartC) begin
        cntQ   <= 16'd1;
        ctlQ   <= isStartC;
        inPktQ <= 1'b1;
      end else begin
        cntQ <= cntQ + 16'd1;
        if (isEnd) inPktQ <= 1'b0;
      end
    end
  end

  a_r7_k_only_symbols: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outK) |-> (isStartT || isStartC || isEnd));

  a_r8_no_ready_tlp_start: assert property (@(posedge clk) disable iff (!rstN)
    isStartT |-> !inReady);

  a_r8_no_ready_at_end: assert property (@(posedge clk) disable iff (!rstN)
    isEnd |-> !inReady);

  a_r8_start_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (isStartT || isStartC) |-> !inPktQ);

  a_r2_end_inside_packet: assert property (@(posedge clk) disable iff (!rstN)
    isEnd |-> inPktQ);

  a_r3_seq_top_zero: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outK && inPktQ && !ctlQ && cntQ == 16'd1) |-> ((outData >> (SEQ_W - 8)) == 8'd0));

  a_r5_ctl_length: assert property (@(posedge clk) disable iff (!rstN)
    (isEnd && ctlQ) |-> (cntQ == 16'(CTL_BODY_BYTES + 3)));
endmodule

bind link_framer link_framer_chk #(
  .SEQ_W(SEQ_W), .CTL_BODY_BYTES(CTL_BODY_BYTES),
  .START_TLP_SYM(START_TLP_SYM), .START_CTL_SYM(START_CTL_SYM), .END_SYM(END_SYM)
) uChk (
  .clk(clk), .rstN(rstN), .inReady(inReady),
  .outValid(outValid), .outData(outData), .outK(outK)
);

// File: tb/sim_link_framer.sv
`timescale 1ns/1ps
module sim_link_framer;
  logic clk = 1'b0;
  logic rstN;
  logic inValid, inReady, inLast, inCtrl;
  logic [7:0] inData;
  logic outValid, outK;
  logic [7:0] outData;

  always #2.5 clk = ~clk;

  link_framer u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inData(inData), .inLast(inLast), .inCtrl(inCtrl),
    .outValid(outValid), .outData(outData), .outK(outK)
  );

  int vecs = 0;
  int errs = 0;
  bit done = 1'b0;
  int seqExp = 0;

  // Output capture ring
  logic [8:0] capD [0:255];
  logic       capR [0:255];
  int capN = 0;
  always @(negedge clk) begin
    if (outValid) begin
      capD[capN % 256] = {outK, outData};
      capR[capN % 256] = inReady;
      capN = capN + 1;
    end
  end

  logic [7:0] body [0:63];
  logic [8:0] expD [0:127];
  bit         expRdyLow [0:127];
  int         expTag [0:127];
  int         expLen;

  function automatic logic [31:0] step32(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[31] ^ b[i]) ? ((r << 1) ^ 32'h04C11DB7) : (r << 1);
    return r;
  endfunction

  function automatic logic [15:0] step16(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 7; i >= 0; i--) r = (r[15] ^ b[i]) ? ((r << 1) ^ 16'h100B) : (r << 1);
    return r;
  endfunction

  function automatic string tagName(input int t);
    case (t)
      1: return "R3";
      2: return "R2";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit k, input logic [7:0] d, input bit rl, input int tg);
    expD[expLen] = {k, d};
    expRdyLow[expLen] = rl;
    expTag[expLen] = tg;
    expLen++;
  endtask

  task automatic buildExpected(input bit ctl, input int n);
    logic [31:0] c32 = 32'hFFFFFFFF;
    logic [15:0] c16 = 16'hFFFF;
    logic [7:0] hi, lo;
    expLen = 0;
    if (!ctl) begin
      hi = {4'b0, 4'(seqExp >> 8)};
      lo = 8'(seqExp);
      push(1'b1, 8'hFB, 1'b1, 0);
      push(1'b0, hi, 1'b1, 1); c32 = step32(c32, hi);
      push(1'b0, lo, 1'b0, 1); c32 = step32(c32, lo);
      for (int i = 0; i < n; i++) begin
        push(1'b0, body[i], i == n - 1, 2);
        c32 = step32(c32, body[i]);
      end
      c32 = ~c32;
      push(1'b0, c32[31:24], 1'b1, 3);
      push(1'b0, c32[23:16], 1'b1, 3);
      push(1'b0, c32[15:8],  1'b1, 3);
      push(1'b0, c32[7:0],   1'b1, 3);
    end else begin
      push(1'b1, 8'h5C, 1'b0, 0);
      for (int i = 0; i < 4; i++) begin
        push(1'b0, body[i], i == 3, 4);
        c16 = step16(c16, body[i]);
      end
      push(1'b0, c16[15:8], 1'b1, 5);
      push(1'b0, c16[7:0],  1'b1, 5);
    end
    push(1'b1, 8'hFD, 1'b1, 0);
  endtask

  // Drive one packet, then compare every emitted byte and ready level
  task automatic sendPkt(input bit ctl, input int n, input int gapEvery, input int lastAt);
    int base;
    int idx = 0;
    int cyc = 0;
    int t = 0;
    buildExpected(ctl, n);
    base = capN;
    while (idx < n) begin
      @(negedge clk);
      cyc++;
      if (gapEvery != 0 && (cyc % gapEvery) == 0) begin
        inValid = 1'b0;
      end else begin
        inValid = 1'b1;
        inData  = body[idx];
        inCtrl  = ctl;
        inLast  = ctl ? (idx == lastAt) : (idx == n - 1);
        if (inReady) idx++;
      end
    end
    @(negedge clk);
    inValid = 1'b0;
    inLast  = 1'b0;
    while ((capN - base) < expLen && t < 400) begin
      @(negedge clk);
      t++;
    end
    @(negedge clk);
    check((capN - base) == expLen, ctl ? "R5 length" : "R2 length", capN - base, expLen);
    for (int i = 0; i < expLen; i++) begin
      check(capD[(base + i) % 256] == expD[i], tagName(expTag[i]),
            int'(capD[(base + i) % 256]), int'(expD[i]));
      if (expRdyLow[i])
        check(capR[(base + i) % 256] == 1'b0, "R8 ready low", int'(capR[(base + i) % 256]), 0);
    end
    if (!ctl) seqExp = (seqExp + 1) % 4096;
  endtask

  task automatic testReset;
    rstN = 1'b0; inValid = 1'b0; inLast = 1'b0; inCtrl = 1'b0; inData = '0;
    repeat (4) @(negedge clk);
    check(outValid == 1'b0, "R1 outValid in reset", int'(outValid), 0);
    check(inReady == 1'b0, "R1 inReady in reset", int'(inReady), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(outValid == 1'b0, "R1 outValid idle", int'(outValid), 0);
    check(inReady == 1'b0, "R1 inReady idle", int'(inReady), 0);
  endtask

  task automatic testTlpHeaderOnly;  // R1 R2 R3 R4 R7 R8: sequence 0 first
    for (int i = 0; i < 12; i++) body[i] = 8'(8'h10 + i * 7);
    sendPkt(1'b0, 12, 0, 0);
  endtask

  task automatic testTlpPayloadStalls;  // R10 R4
    for (int i = 0; i < 48; i++) body[i] = 8'(i * 37 + 3);
    sendPkt(1'b0, 48, 3, 0);
  endtask

  task automatic testCtlEarlyLast;  // R5 R6: inLast on byte 1 has no effect
    body[0] = 8'hA5; body[1] = 8'h00; body[2] = 8'hFF; body[3] = 8'h3C;
    sendPkt(1'b1, 4, 0, 1);
    body[0] = 8'h01; body[1] = 8'h02; body[2] = 8'h03; body[3] = 8'h04;
    sendPkt(1'b1, 4, 2, 0);
  endtask

  task automatic testSeqAfterCtl;  // R9: sequence not advanced by control packets
    for (int i = 0; i < 16; i++) body[i] = 8'(8'hC0 ^ i);
    sendPkt(1'b0, 16, 0, 0);
  endtask

  task automatic testSeqWrap;  // R3: wrap 4095 -> 0
    int start = seqExp;
    for (int p = 0; p < 4100 - start; p++) begin
      body[0] = 8'(p);
      sendPkt(1'b0, 1, 0, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R2 watchdog actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    testReset();
    testTlpHeaderOnly();
    testTlpPayloadStalls();
    testCtlEarlyLast();
    testSeqAfterCtl();
    testSeqWrap();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule